// File: doc/BRIEF.md
# Halt Mode Wake-Up Controller

This block puts a processor into a low-power halt state and decides when that state ends. A halt request latches a 2-bit mode code. The mode selects which clock domains stop. The CPU clock is always gated. Peripheral groups are gated fully, or kept per group through a select vector. The oscillator is stopped only in the deepest mode. The always-on domain, which holds the real-time clock, is never gated.

While halted, the block arbitrates wake sources every cycle. The sources are the non-maskable interrupt and a vector of leveled interrupt requests. Each request level is compared against a 3-bit mask. A request whose level lies strictly above the mask is serviced on exit. A designated subset of sources still ends the halt when masked, but the CPU only resumes, and the request stays pending in the interrupt controller.

Waking from the deepest mode restarts the oscillator first. A programmable down-counter then holds the clocks off until the oscillator has settled. Exit ends in a one-cycle wake pulse that carries a cause code and the index of the winning source.

Top module: `halt_wake_ctrl`

## Requirements
- R1: On `halt_req` while running, `halt_mode` is latched and the block halts. The codes are 11 = light idle, 10 = deep idle and 01 = stop. Code 00 leaves the block running.
- R2: While halted, `cpu_clk_en` is 0. In deep idle and stop, `periph_clk_en` is all zeros. In light idle it equals `periph_sel`, where bit set = group keeps running. While running it is all ones.
- R3: `aon_clk_en` is 1 in every state. `osc_en` is 0 only while halted in stop mode, before the wake condition.
- R4: A request whose level is strictly greater than `mask_lvl` ends the halt with cause 01. An ordinary request with level equal to or below the mask does not end it.
- R5: `nmi` ends the halt in any mode whatever the mask. It gives cause 11 with `wake_src` 0 and wins over every other source.
- R6: A source flagged in `SPECIAL_SRC` whose level is not above the mask ends the halt with cause 10 (resume only). `wake_src` gives its index, lowest index first.
- R7: Among serviceable requests, the highest level wins, and the lowest index wins a tie. A serviceable request wins over a masked special source.
- R8: Exit from the idle modes gives `wake` and `cpu_clk_en` on the first edge after the wake condition is sampled. Exit from stop gives them `settle_cnt`+1 edges later than that (settle_cnt+2 in all). `osc_en` is 1 and `cpu_clk_en` is 0 in between.
- R9: `wake` is a one-cycle pulse. `wake_cause` and `wake_src` read 0 whenever `wake` is low.
- R10: `halt_req` received while halted or settling is ignored. The mode and the gating stay as first latched.
- R11: Asserting `rst_n` low ends any halt at once, with the CPU and peripheral clocks enabled and no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt instruction strobe |
| halt_mode | input | 2 | Requested halt mode code |
| periph_sel | input | NUM_PERIPH | Per-group keep-running select for light idle |
| mask_lvl | input | LVL_W | Current interrupt mask level |
| settle_cnt | input | SETTLE_W | Oscillator settling wait, in cycles |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | NUM_IRQ | Maskable interrupt request flags |
| irq_lvl | input | NUM_IRQ*LVL_W | Packed request levels, source i at bits i*LVL_W upward |
| halted | output | 1 | High while halted or settling |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | NUM_PERIPH | Peripheral group clock enables |
| aon_clk_en | output | 1 | Always-on domain clock enable |
| osc_en | output | 1 | Main oscillator enable |
| wake | output | 1 | One-cycle wake pulse |
| wake_cause | output | 2 | 00 none, 01 serviced, 10 resume only, 11 NMI |
| wake_src | output | $clog2(NUM_IRQ) | Index of the winning maskable source |

## Verification
The bench builds the block with eight sources, four peripheral groups, an 8-bit settle counter and `SPECIAL_SRC` = 8'hC1. With these values, masked special sources (0, 6, 7) sit next to ordinary ones, so masked wake and silent masking can be checked against the same mask. The short counter makes the stop-exit window countable edge by edge, including a settle value of zero.

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int NUM_IRQ    = 8,
  parameter int LVL_W      = 3,
  parameter int NUM_PERIPH = 4,
  parameter int SETTLE_W   = 16,
  parameter logic [NUM_IRQ-1:0] SPECIAL_SRC = NUM_IRQ'(193),
  localparam int IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     halt_req,
  input  logic [1:0]               halt_mode,
  input  logic [NUM_PERIPH-1:0]    periph_sel,
  input  logic [LVL_W-1:0]         mask_lvl,
  input  logic [SETTLE_W-1:0]      settle_cnt,
  input  logic                     nmi,
  input  logic [NUM_IRQ-1:0]       irq_req,
  input  logic [NUM_IRQ*LVL_W-1:0] irq_lvl,
  output logic                     halted,
  output logic                     cpu_clk_en,
  output logic [NUM_PERIPH-1:0]    periph_clk_en,
  output logic                     aon_clk_en,
  output logic                     osc_en,
  output logic                     wake,
  output logic [1:0]               wake_cause,
  output logic [IDX_W-1:0]         wake_src
);

  localparam logic [1:0] M_STOP  = 2'b01;
  localparam logic [1:0] M_IDLE2 = 2'b11;

  typedef enum logic [1:0] {S_RUN, S_HALT, S_SETTLE} st_t;

  st_t                st;
  logic [1:0]         mode_q;
  logic [SETTLE_W-1:0] cnt;
  logic [1:0]         pend_cause;
  logic [IDX_W-1:0]   pend_src;

  logic               svc_hit, spc_hit;
  logic [IDX_W-1:0]   svc_idx, spc_idx;
  logic [LVL_W-1:0]   svc_lvl;

  always_comb begin
    logic [LVL_W-1:0] lvl;
    lvl = '0;
    svc_hit = 1'b0; svc_idx = '0; svc_lvl = '0;
    spc_hit = 1'b0; spc_idx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      lvl = irq_lvl[i*LVL_W +: LVL_W];
      if (irq_req[i] && lvl > mask_lvl && (!svc_hit || lvl > svc_lvl)) begin
        svc_hit = 1'b1;
        svc_lvl = lvl;
        svc_idx = IDX_W'(i);
      end
      if (irq_req[i] && SPECIAL_SRC[i] && lvl <= mask_lvl && !spc_hit) begin
        spc_hit = 1'b1;
        spc_idx = IDX_W'(i);
      end
    end
  end

  wire             wake_hit  = nmi | svc_hit | spc_hit;
  wire [1:0]       hit_cause = nmi ? 2'b11 : svc_hit ? 2'b01 : spc_hit ? 2'b10 : 2'b00;
  wire [IDX_W-1:0] hit_idx   = nmi ? '0 : svc_hit ? svc_idx : spc_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      mode_q     <= 2'b00;
      cnt        <= '0;
      pend_cause <= 2'b00;
      pend_src   <= '0;
      wake       <= 1'b0;
      wake_cause <= 2'b00;
      wake_src   <= '0;
    end else begin
      wake       <= 1'b0;
      wake_cause <= 2'b00;
      wake_src   <= '0;
      case (st)
        S_RUN: if (halt_req && halt_mode != 2'b00) begin
          st     <= S_HALT;
          mode_q <= halt_mode;
        end
        S_HALT: if (wake_hit) begin
          pend_cause <= hit_cause;
          pend_src   <= hit_idx;
          if (mode_q == M_STOP) begin
            st  <= S_SETTLE;
            cnt <= settle_cnt;
          end else begin
            st         <= S_RUN;
            wake       <= 1'b1;
            wake_cause <= hit_cause;
            wake_src   <= hit_idx;
          end
        end
        S_SETTLE: if (cnt == '0) begin
          st         <= S_RUN;
          wake       <= 1'b1;
          wake_cause <= pend_cause;
          wake_src   <= pend_src;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign halted        = (st != S_RUN);
  assign cpu_clk_en    = (st == S_RUN);
  assign aon_clk_en    = 1'b1;
  assign osc_en        = !(st == S_HALT && mode_q == M_STOP);
  assign periph_clk_en = (st == S_RUN) ? '1 :
                         (st == S_HALT && mode_q == M_IDLE2) ? periph_sel : '0;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  a_r9_cause_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> wake_cause != 2'b00);
  a_r2_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !cpu_clk_en);
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN && halt_req) |=> $stable(mode_q));
  a_r8_clock_with_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake);
  a_r3_osc_back_before_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(osc_en));

endmodule

// File: tb/halt_wake_ctrl_test.sv
`timescale 1ns/1ps
module halt_wake_ctrl_test;
  localparam int NI = 8, LW = 3, NP = 4, SW = 8;

  logic clk = 0, rst_n = 0, halt_req = 0, nmi = 0;
  logic [1:0] halt_mode = 0;
  logic [NP-1:0] periph_sel = 0;
  logic [LW-1:0] mask_lvl = 0;
  logic [SW-1:0] settle_cnt = 0;
  logic [NI-1:0] irq_req = 0;
  logic [NI*LW-1:0] irq_lvl = 0;
  logic halted, cpu_clk_en, aon_clk_en, osc_en, wake;
  logic [NP-1:0] periph_clk_en;
  logic [1:0] wake_cause;
  logic [2:0] wake_src;

  int n_chk = 0, n_fail = 0;

  halt_wake_ctrl #(.NUM_IRQ(NI), .LVL_W(LW), .NUM_PERIPH(NP), .SETTLE_W(SW),
                   .SPECIAL_SRC(8'hC1)) uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_irq(input int idx, input logic [LW-1:0] lvl);
    irq_req[idx] = 1'b1;
    irq_lvl[idx*LW +: LW] = lvl;
  endtask

  task automatic enter_halt(input logic [1:0] m);
    @(negedge clk); halt_req = 1; halt_mode = m;
    @(negedge clk); halt_req = 0;
  endtask

  task automatic wait_wake(input string tag, input int exp_d, input logic [1:0] exp_c,
                           input logic [2:0] exp_s);
    int d = 0;
    do begin @(negedge clk); d++; end while (!wake && d < 100);
    chk({tag, " delay"}, d, exp_d);
    chk({tag, " cause"}, wake_cause, exp_c);
    chk({tag, " src"}, wake_src, exp_s);
    chk({tag, " cpu on"}, cpu_clk_en, 1);
    irq_req = 0; nmi = 0;
    @(negedge clk);
    chk("R9 pulse ends", {wake, wake_cause, wake_src}, 0);
  endtask

  task automatic t_reset;
    chk("R11 reset halted", halted, 0);
    chk("R11 reset cpu", cpu_clk_en, 1);
    chk("R2 run periph", periph_clk_en, 4'hF);
    chk("R3 aon", aon_clk_en, 1);
    chk("R3 osc run", osc_en, 1);
    chk("R9 no wake", {wake, wake_cause}, 0);
  endtask

  task automatic t_idle2;
    periph_sel = 4'b1010; mask_lvl = 2;
    enter_halt(2'b11);
    chk("R1 idle2 halted", halted, 1);
    chk("R2 idle2 cpu", cpu_clk_en, 0);
    chk("R2 idle2 periph", periph_clk_en, 4'b1010);
    chk("R3 idle2 osc", osc_en, 1);
    chk("R3 idle2 aon", aon_clk_en, 1);
    set_irq(3, 5);
    wait_wake("R4 serviced", 1, 2'b01, 3);
  endtask

  task automatic t_idle1_masked;
    mask_lvl = 3;
    enter_halt(2'b10);
    chk("R2 idle1 periph", periph_clk_en, 0);
    set_irq(2, 3); set_irq(4, 1);
    repeat (10) @(negedge clk);
    chk("R4 equal level no wake", {halted, wake}, 2'b10);
    nmi = 1;
    wait_wake("R5 nmi", 1, 2'b11, 0);
  endtask

  task automatic t_special;
    mask_lvl = 4;
    enter_halt(2'b11);
    set_irq(6, 1); set_irq(7, 4); set_irq(5, 2);
    wait_wake("R6 special", 1, 2'b10, 6);
    enter_halt(2'b10);
    set_irq(0, 7); set_irq(6, 1);
    wait_wake("R7 serviced beats special", 1, 2'b01, 0);
  endtask

  task automatic t_priority;
    mask_lvl = 2;
    enter_halt(2'b11);
    set_irq(1, 4); set_irq(5, 6); set_irq(2, 6);
    wait_wake("R7 highest level low index", 1, 2'b01, 2);
    enter_halt(2'b10);
    set_irq(4, 7); nmi = 1;
    wait_wake("R5 nmi wins", 1, 2'b11, 0);
  endtask

  task automatic t_stop(input int n);
    settle_cnt = SW'(n); mask_lvl = 1;
    enter_halt(2'b01);
    chk("R3 stop osc off", osc_en, 0);
    chk("R2 stop periph", periph_clk_en, 0);
    set_irq(3, 2);
    @(negedge clk);
    chk("R8 settling osc on", osc_en, 1);
    chk("R8 settling cpu off", {halted, cpu_clk_en}, 2'b10);
    wait_wake("R8 stop exit", n + 1, 2'b01, 3);
  endtask

  task automatic t_rehalt;
    periph_sel = 4'b0110; mask_lvl = 0;
    enter_halt(2'b11);
    enter_halt(2'b01);
    chk("R10 periph kept", periph_clk_en, 4'b0110);
    chk("R10 osc kept", osc_en, 1);
    set_irq(1, 1);
    wait_wake("R10 idle exit kept", 1, 2'b01, 1);
    enter_halt(2'b00);
    chk("R1 code 00 ignored", halted, 0);
  endtask

  task automatic t_reset_in_stop;
    settle_cnt = 8'd20;
    enter_halt(2'b01);
    rst_n = 0; #1;
    chk("R11 reset exits", {halted, cpu_clk_en, osc_en}, 3'b011);
    chk("R11 reset periph", periph_clk_en, 4'hF);
    chk("R11 no wake", wake, 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle2();
    t_idle1_masked();
    t_special();
    t_priority();
    t_stop(5);
    t_stop(0);
    t_rehalt();
    t_reset_in_stop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule